// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

This block is a decade counter whose state is held in a five-stage twisted-ring (Johnson) register. It drives ten one-hot decoded outputs and an active-low carry. The carry is high in the lower five states and low in the upper five, so it can feed the rising-edge count input of a following counter.

There are two count inputs. One advances the counter on its rising edge. The other advances it on its falling edge. Each input acts as the enable of the other, so either can serve as the clock while the other gates it. Both inputs are synchronized into the system clock domain and edge-detected there.

An active-high clear forces state 0 at once, without waiting for a clock. Its release is resynchronized so that counting resumes cleanly. Any illegal ring code is repaired by the next count pulse.

Top module: `johnson_decade`

## Requirements
- R1: The legal ring codes, written ring[4:0], are state 0 = 00000, 1 = 00001, 2 = 00011, 3 = 00111, 4 = 01111, 5 = 11111, 6 = 11110, 7 = 11100, 8 = 11000 and 9 = 10000. In legal state k, dec_o is one-hot with only bit k set.
- R2: A rising edge on adv_rise_i while adv_fall_i is low advances the state by one, and state 9 wraps to state 0.
- R3: A falling edge on adv_fall_i while adv_rise_i is high advances the state by one.
- R4: Every other input combination leaves the state unchanged. This includes a falling adv_rise_i, a rising adv_fall_i, adv_rise_i held low, adv_fall_i held high, and both inputs held steady.
- R5: carry_n_o is 1 in states 0 to 4 and 0 in states 5 to 9. It is the inverse of ring bit 4.
- R6: While clear_i is high, the outputs show state 0 (dec_o = 1, carry_n_o = 1) without waiting for a clock edge. Edges on the count inputs have no effect while clear is high, nor for two clock edges after it falls.
- R7: From any of the 22 illegal codes, the next count pulse loads state 0. This is well inside the bound of 11 counts.
- R8: Switching the gating input produces exactly one count in each of these cases:
  - adv_fall_i falls while adv_rise_i is high;
  - adv_rise_i rises while adv_fall_i is already low;
  - adv_rise_i rises in the same cycle that adv_fall_i falls.
- R9: When carry_n_o of one counter drives adv_rise_i of a second counter (whose adv_fall_i is tied low), the second counter advances exactly when the first wraps from 9 to 0.
- R10: A count input change applied between clock edges first shows on the outputs after the third rising clock edge that follows it. After the second edge the outputs are still unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| clear_i | input | 1 | Asynchronous clear, active high |
| adv_rise_i | input | 1 | Count input, rising-edge active, gated by adv_fall_i low |
| adv_fall_i | input | 1 | Count input, falling-edge active, gated by adv_rise_i high |
| dec_o | output | 10 | One-hot decoded state |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The assertions assume that the ring register changes only at clock edges or through clear. A legal-code check is therefore meaningful only between count pulses.

The bench plants illegal codes by forcing the register. It does this only between clock edges, with both count inputs held still, so no step is pending at the surrounding edges.

Every count input change is held for several cycles before the next one, so the two-flop synchronizers never see a pulse shorter than the detection window. Clear pulses used to check counter state last long enough to cover the resynchronized release. The one short pulse is applied from state 0, where the carry does not move.

// File: rtl/johnson_decade.sv
module johnson_decade #(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  clear_i,
  input  logic                  adv_rise_i,
  input  logic                  adv_fall_i,
  output logic [2*STAGES-1:0]   dec_o,
  output logic                  carry_n_o
);
  localparam int STATES = 2 * STAGES;

  logic [SYNC_DEPTH-1:0] rise_sync, fall_sync;
  logic                  rise_prev, fall_prev;
  logic [1:0]            clr_q;
  logic [STAGES-1:0]     ring_q;
  logic                  rise_lvl, fall_lvl, step, code_ok;

  always_ff @(posedge clk_i) begin
    rise_sync <= {rise_sync[SYNC_DEPTH-2:0], adv_rise_i};
    fall_sync <= {fall_sync[SYNC_DEPTH-2:0], adv_fall_i};
    rise_prev <= rise_lvl;
    fall_prev <= fall_lvl;
  end

  assign rise_lvl = rise_sync[SYNC_DEPTH-1];
  assign fall_lvl = fall_sync[SYNC_DEPTH-1];

  always_ff @(posedge clk_i or posedge clear_i)
    if (clear_i) clr_q <= 2'b11;
    else         clr_q <= {clr_q[0], 1'b0};

  assign step = !clr_q[1] &&
                ((rise_lvl && !rise_prev && !fall_lvl) ||
                 (!fall_lvl && fall_prev && rise_lvl));

  assign code_ok = $countones(ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0]) <= 1;

  always_ff @(posedge clk_i or posedge clear_i)
    if (clear_i)       ring_q <= '0;
    else if (clr_q[1]) ring_q <= '0;
    else if (step)     ring_q <= code_ok ? {ring_q[STAGES-2:0], ~ring_q[STAGES-1]} : '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_dec
    if (k == 0) begin : g_end
      assign dec_o[0]      = ~ring_q[STAGES-1] & ~ring_q[0];
      assign dec_o[STAGES] =  ring_q[STAGES-1] &  ring_q[0];
    end else begin : g_mid
      assign dec_o[k]        =  ring_q[k-1] & ~ring_q[k];
      assign dec_o[STAGES+k] = ~ring_q[k-1] &  ring_q[k];
    end
  end

  assign carry_n_o = ~ring_q[STAGES-1];

  // R1
  one_hot_chk: assert property (@(posedge clk_i) disable iff (clear_i)
    code_ok |-> $countones(dec_o) == 1);

  // R5
  carry_chk: assert property (@(posedge clk_i) disable iff (clear_i)
    code_ok |-> carry_n_o == !(|dec_o[STATES-1:STAGES]));

  // R2
  advance_chk: assert property (@(posedge clk_i) disable iff (clear_i)
    (step && code_ok) |=> dec_o == {$past(dec_o[STATES-2:0]), $past(dec_o[STATES-1])});

  // R7
  repair_chk: assert property (@(posedge clk_i) disable iff (clear_i)
    (step && !code_ok) |=> dec_o == STATES'(1));

  // R6
  clear_chk: assert property (@(posedge clk_i)
    clear_i |-> (dec_o == STATES'(1) && carry_n_o));
endmodule

// File: tb/johnson_decade_tb_top.sv
module johnson_decade_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, clear = 0, a_rise = 0, a_fall = 0;
  logic [9:0] dec, dec2;
  logic carry_n, carry2_n;
  int checks = 0, errs = 0, cnt = 0, cnt2 = 0;
  bit done = 0, casc_ok = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  johnson_decade dut_i (.clk_i(clk), .clear_i(clear), .adv_rise_i(a_rise),
                        .adv_fall_i(a_fall), .dec_o(dec), .carry_n_o(carry_n));
  johnson_decade casc_i (.clk_i(clk), .clear_i(clear), .adv_rise_i(carry_n),
                         .adv_fall_i(1'b0), .dec_o(dec2), .carry_n_o(carry2_n));

  function automatic int legal_code(int k);
    return (k <= 5) ? ((1 << k) - 1) : ((31 << (k - 5)) & 31);
  endfunction

  function automatic bit is_legal(int c);
    for (int k = 0; k < 10; k++) if (legal_code(k) == c) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(tag, int'(dec), 1 << cnt);
    chk("R5 carry", int'(carry_n), (cnt < 5) ? 1 : 0);
    if (casc_ok) chk("R9 cascade", int'(dec2), 1 << cnt2);
  endtask

  task automatic apply(input logic n0, input logic n1);
    bit ev;
    string tag;
    ev = (n0 && !a_rise && !n1) || (!n1 && a_fall && n0);
    if (!ev) tag = "R4 hold";
    else if (n0 && !a_rise) tag = (a_fall && !n1) ? "R8 both" : "R2 rise";
    else tag = "R3 fall";
    a_rise = n0;
    a_fall = n1;
    repeat (8) @(negedge clk);
    if (ev) begin
      if (cnt == 9) begin cnt = 0; cnt2 = (cnt2 + 1) % 10; end
      else cnt++;
    end
    chk_state(tag);
  endtask

  task automatic long_clear();
    @(negedge clk);
    clear = 1;
    #1;
    chk("R6 immediate dec", int'(dec), 1);
    chk("R6 immediate carry", int'(carry_n), 1);
    a_rise = 1;
    repeat (2) @(negedge clk);
    a_fall = 1;
    repeat (2) @(negedge clk);
    a_rise = 0;
    a_fall = 0;
    repeat (4) @(negedge clk);
    clear = 0;
    repeat (6) @(negedge clk);
    cnt = 0;
    cnt2 = 0;
    casc_ok = 1;
    chk_state("R6 after clear");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #1 clear = 1;
    repeat (6) @(negedge clk);
    clear = 0;
    repeat (6) @(negedge clk);
    chk_state("R6 reset state");

    // R10 latency
    a_rise = 1;
    repeat (2) @(negedge clk);
    chk("R10 after two edges", int'(dec), 1);
    @(negedge clk);
    chk("R10 after three edges", int'(dec), 2);
    repeat (5) @(negedge clk);
    cnt = 1;
    apply(0, 0);

    // R2, R3, R4, R8 directed gating combinations
    apply(0, 1);
    apply(1, 1);
    apply(1, 0);
    apply(0, 0);
    apply(1, 0);
    apply(1, 1);
    apply(1, 0);
    apply(0, 1);
    apply(1, 0);
    apply(0, 0);
    apply(0, 1);

    // R9 through full wraps
    for (int i = 0; i < 24; i++) begin
      apply(1, 0);
      apply(0, 0);
    end

    // random mix
    for (int i = 0; i < 400; i++) apply(1'($urandom), 1'($urandom));

    // R6 clear with mid-flight count
    long_clear();
    a_rise = 1;
    @(negedge clk);
    clear = 1;
    #1 chk("R6 mid-count dec", int'(dec), 1);
    @(negedge clk);
    clear = 0;
    repeat (8) @(negedge clk);
    chk_state("R6 mid-count lost");
    apply(0, 0);
    apply(1, 0);
    apply(0, 0);

    // R7 illegal codes
    casc_ok = 0;
    for (int c = 0; c < 32; c++) begin
      if (is_legal(c)) continue;
      @(negedge clk);
      force dut_i.ring_q = 5'(c);
      #1 release dut_i.ring_q;
      repeat (2) @(negedge clk);
      cnt = 0;
      a_rise = 1;
      repeat (8) @(negedge clk);
      chk($sformatf("R7 code %0d dec", c), int'(dec), 1);
      chk($sformatf("R7 code %0d carry", c), int'(carry_n), 1);
      apply(0, 0);
    end
    long_clear();
    for (int i = 0; i < 60; i++) apply(1'($urandom), 1'($urandom));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule